// File: doc/BRIEF.md
# Software Command Sequence Detector for a Nonvolatile SRAM

This block watches the read and write cycles that a host issues to a battery-free nonvolatile SRAM. It looks for a software command: six read cycles whose addresses arrive in a fixed order. The first five addresses are common to both commands. The sixth address chooses between copying the SRAM into the nonvolatile array (store) and copying the nonvolatile array back into the SRAM (recall). The cycles themselves still go through as ordinary reads. The detector only observes them and, when it recognises a full command, raises a single-clock request on the matching output for the controller that carries the operation out.

Each bus cycle is presented for one clock on `cyc_valid`, together with the 15-bit address and the active-low write strobe. A write cycle breaks the sequence. So does an address that does not match the expected step. Clocks on which `cyc_valid` is low are not bus cycles and leave the progress unchanged.

Top module: `nvsram_cmd_detect`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears both outputs and discards any partly matched sequence. After reset, a full six-step command is needed before a pulse can appear.
- R2: The shared prefix is the five read addresses 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F, in that order. Each must occupy its own valid cycle.
- R3: If the valid read cycle that follows the prefix carries address 0x0FC0, `store_req` is high for exactly one clock, on the clock after that cycle's edge.
- R4: If the valid read cycle that follows the prefix carries address 0x0C63, `recall_req` is high for exactly one clock, on the clock after that cycle's edge.
- R5: Only address bits 13:0 are compared. Bit 14 may take either value on any step without changing the result.
- R6: A valid cycle with `wr_n` low discards all progress and produces no pulse, even when its address is the expected one.
- R7: A valid read whose address is not the expected next step restarts matching. If that same address equals 0x0E38, it counts as step one of a new sequence.
- R8: Clocks with `cyc_valid` low neither advance nor reset the match, so idle gaps between the six cycles are allowed.
- R9: `store_req` and `recall_req` are never high together. After a command the detector is idle, so repeating the sixth address alone produces no further pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_valid | input | 1 | High for one clock per bus cycle |
| addr | input | 15 | Address of the current bus cycle |
| wr_n | input | 1 | Write strobe, active low; high marks a read |
| store_req | output | 1 | One-clock request to start a nonvolatile store |
| recall_req | output | 1 | One-clock request to start a nonvolatile recall |

## Verification
Two functions can fall in the same cycle: a mismatch that abandons a partly matched sequence, and the first step of a new sequence. This happens when the cycle that breaks a sequence carries 0x0E38, most sharply at the sixth position where a command would otherwise complete. The bench provokes this case directly. It then sends the remaining five addresses and expects exactly one store pulse, with no pulse on the breaking cycle. The same overlap also arises in the random stream, because that stream draws mostly from the sequence addresses, with bit 14 and the write strobe randomised. Every cycle is judged against a reference step count kept in the bench.

// File: rtl/nvsram_cmd_detect.sv
module nvsram_cmd_detect #(
  parameter int ADDR_W = 15,
  parameter int CMP_W  = 14,
  parameter logic [CMP_W-1:0] SEQ0 = 14'h0E38,
  parameter logic [CMP_W-1:0] SEQ1 = 14'h31C7,
  parameter logic [CMP_W-1:0] SEQ2 = 14'h03E0,
  parameter logic [CMP_W-1:0] SEQ3 = 14'h3C1F,
  parameter logic [CMP_W-1:0] SEQ4 = 14'h303F,
  parameter logic [CMP_W-1:0] STORE_A  = 14'h0FC0,
  parameter logic [CMP_W-1:0] RECALL_A = 14'h0C63
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_n,
  output logic              store_req,
  output logic              recall_req
);
  localparam int STEPS = 6;
  localparam int SW = $clog2(STEPS);
  localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

  logic [SW-1:0]    step;
  logic [CMP_W-1:0] key, expect_a;
  logic             at_last, rd, hit_pre, hit_store, hit_recall, is_first;

  always_comb begin
    case (step)
      SW'(0):  expect_a = SEQ0;
      SW'(1):  expect_a = SEQ1;
      SW'(2):  expect_a = SEQ2;
      SW'(3):  expect_a = SEQ3;
      default: expect_a = SEQ4;
    endcase
  end

  assign key        = addr[CMP_W-1:0];
  assign rd         = cyc_valid && wr_n;
  assign at_last    = step == LAST;
  assign hit_pre    = !at_last && key == expect_a;
  assign hit_store  = at_last && key == STORE_A;
  assign hit_recall = at_last && key == RECALL_A;
  assign is_first   = key == SEQ0;

  always_ff @(posedge clk) begin
    if (rst) begin
      step       <= '0;
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      store_req  <= rd && hit_store;
      recall_req <= rd && hit_recall;
      if (cyc_valid) begin
        if (!wr_n)                      step <= '0;
        else if (hit_pre)               step <= step + SW'(1);
        else if (hit_store||hit_recall) step <= '0;
        else                            step <= is_first ? SW'(1) : '0;
      end
    end
  end

  // R9
  one_kind_chk: assert property (@(posedge clk) disable iff (rst)
    !(store_req && recall_req));

  // R3
  store_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    store_req |-> ($past(step) == LAST && $past(cyc_valid) && $past(wr_n)));

  // R4
  recall_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    recall_req |-> ($past(step) == LAST && $past(cyc_valid) && $past(wr_n)));

  // R6
  write_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && !wr_n) |=> (step == '0 && !store_req && !recall_req));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cyc_valid |=> $stable(step));

  // R5
  top_bit_recall_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && at_last && addr[ADDR_W-1] && addr[CMP_W-1:0] == RECALL_A) |=> recall_req);

  // R9
  step_range_chk: assert property (@(posedge clk) disable iff (rst)
    step <= LAST);
endmodule

// File: tb/nvsram_cmd_detect_bench.sv
`timescale 1ns/1ps
module nvsram_cmd_detect_bench;
  logic clk = 0, rst = 1, cyc_valid = 0, wr_n = 1;
  logic [14:0] addr = '0;
  logic store_req, recall_req;
  int checks = 0, errors = 0, ms = 0;
  bit done = 0;

  localparam logic [13:0] A0 = 14'h0E38, A1 = 14'h31C7, A2 = 14'h03E0,
                          A3 = 14'h3C1F, A4 = 14'h303F,
                          AST = 14'h0FC0, ARC = 14'h0C63;

  always #2.5 clk = ~clk;

  nvsram_cmd_detect u_nvsram_cmd_detect (
    .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .addr(addr), .wr_n(wr_n),
    .store_req(store_req), .recall_req(recall_req));

  function automatic logic [13:0] seq_at(int i);
    case (i)
      0: return A0; 1: return A1; 2: return A2; 3: return A3; default: return A4;
    endcase
  endfunction

  task automatic check(string tag, logic es, logic er);
    checks++;
    if (store_req !== es || recall_req !== er) begin
      errors++;
      $display("FAIL %s store/recall got %b%b expected %b%b at %0t",
               tag, store_req, recall_req, es, er, $time);
    end
  endtask

  task automatic bus(logic [14:0] a, logic wn, string tag);
    logic [13:0] k = a[13:0];
    logic es = 0, er = 0;
    if (!wn) ms = 0;
    else if (ms == 5) begin
      if (k == AST) begin es = 1; ms = 0; end
      else if (k == ARC) begin er = 1; ms = 0; end
      else ms = (k == A0) ? 1 : 0;
    end else if (k == seq_at(ms)) ms++;
    else ms = (k == A0) ? 1 : 0;
    cyc_valid = 1; addr = a; wr_n = wn;
    @(negedge clk);
    cyc_valid = 0; wr_n = 1; addr = $urandom;
    check(tag, es, er);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag, 0, 0);
    end
  endtask

  task automatic do_reset;
    rst = 1; ms = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    check("R1", 0, 0);
  endtask

  task automatic prefix(logic top, string tag);
    for (int i = 0; i < 5; i++) bus({top, seq_at(i)}, 1, tag);
  endtask

  initial begin
    void'($urandom(32'h5EED_0417));
    @(negedge clk);
    do_reset;

    prefix(0, "R2"); bus({1'b0, AST}, 1, "R3");
    idle(2, "R3");
    prefix(0, "R2"); bus({1'b0, ARC}, 1, "R4");
    idle(1, "R4");
    prefix(1, "R5"); bus({1'b1, ARC}, 1, "R5");
    bus({1'b1, A0}, 1, "R5"); bus({1'b0, A1}, 1, "R5"); bus({1'b1, A2}, 1, "R5");
    bus({1'b0, A3}, 1, "R5"); bus({1'b1, A4}, 1, "R5"); bus({1'b1, AST}, 1, "R5");
    for (int i = 0; i < 5; i++) bus({1'b0, seq_at(i)}, i != 3, "R6");
    bus({1'b0, A4}, 1, "R6"); bus({1'b0, AST}, 1, "R6");
    prefix(0, "R6"); bus({1'b0, AST}, 0, "R6");
    bus({1'b0, AST}, 1, "R6");
    prefix(0, "R7"); bus({1'b0, A0}, 1, "R7");
    for (int i = 1; i < 5; i++) bus({1'b0, seq_at(i)}, 1, "R7");
    bus({1'b0, AST}, 1, "R7");
    bus({1'b0, A0}, 1, "R7"); bus({1'b0, A0}, 1, "R7");
    for (int i = 1; i < 5; i++) bus({1'b0, seq_at(i)}, 1, "R7");
    bus({1'b0, ARC}, 1, "R7");
    for (int i = 0; i < 5; i++) begin bus({1'b0, seq_at(i)}, 1, "R8"); idle(i, "R8"); end
    bus({1'b0, AST}, 1, "R8");
    bus({1'b0, AST}, 1, "R9"); bus({1'b0, ARC}, 1, "R9");
    prefix(0, "R1"); do_reset; bus({1'b0, AST}, 1, "R1");

    for (int n = 0; n < 4000; n++) begin
      int sel = $urandom_range(0, 15);
      logic [13:0] k;
      if (sel < 5) k = seq_at(ms < 5 && sel == 0 ? ms : sel);
      else if (sel < 8) k = AST;
      else if (sel < 10) k = ARC;
      else if (sel < 13) k = (ms < 5) ? seq_at(ms) : AST;
      else k = 14'($urandom);
      bus({1'($urandom), k}, $urandom_range(0, 9) != 0, "R9");
      if ($urandom_range(0, 7) == 0) idle($urandom_range(1, 3), "R8");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule